// File: doc/BRIEF.md
# Serial DAC Sample Transmitter

This block sits on the host side of a 16-bit serial digital-to-analog converter. It takes samples from an internal producer through a valid/ready handshake. Each sample goes out as one frame on a three-wire port: an active-low select, a bit clock that rests low, and a data line. A frame carries the 16 bits most significant first. Data changes on falling clock edges so that it is steady around each rising edge, where the converter samples it. The frame keeps the select low through the falling edge that follows the 16th rising edge, because that edge makes the converter update its output.

Every interval the converter needs is a parameter counted in system-clock cycles:
- the half period of the bit clock (`HALF_DIV`),
- the time from select falling to the first rising clock edge (`LEAD_CYC`),
- the minimum time the select stays high between frames (`GAP_CYC`),
- a hold-off after reset (`PWRUP_CYC`, by default 5000 cycles, which is 100 µs at 50 MHz) during which no frame may start.

The controller is a state machine with six states:
- `ST_PWRUP`: hold-off after reset.
- `ST_IDLE`: ready for a sample.
- `ST_LEAD`: select low, clock low.
- `ST_SCK_HI`: clock high.
- `ST_SCK_LO`: clock low, after a falling edge.
- `ST_GAP`: select high between frames.

Its transitions are:
- PWRUP→IDLE when the hold-off timer expires.
- IDLE→LEAD when a sample is accepted.
- LEAD→SCK_HI when the lead time expires.
- SCK_HI→SCK_LO when the half period expires; this transition also shifts the next bit out.
- SCK_LO→SCK_HI when the half period expires and bits remain.
- SCK_LO→GAP when the half period expires after the last bit.
- GAP→IDLE when the gap time expires.

Top module: `dac_spi_host`

## Requirements
- R1: While reset is asserted, `dac_cs_n` is 1, `dac_sclk` is 0, `dac_sdo` is 0 and `in_ready` is 0.
- R2: After reset is released, `in_ready` stays 0 and `dac_cs_n` stays 1 for exactly `PWRUP_CYC` clock edges. `in_ready` rises after edge number `PWRUP_CYC`, and an `in_valid` presented earlier starts no frame.
- R3: A sample is accepted on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `dac_cs_n` is 0 and `in_ready` is 0. `in_ready` stays 0 through the whole frame and the following gap.
- R4: `dac_cs_n` falls on the accepting edge. `dac_sclk` then stays 0 for `LEAD_CYC` cycles before its first rise, and `dac_sdo` already carries bit 15 during that lead time.
- R5: Each frame has exactly 16 rising edges of `dac_sclk`. Each high phase lasts `HALF_DIV` cycles and each low phase between pulses lasts `HALF_DIV` cycles.
- R6: During the high phase of pulse i (i = 0..15), `dac_sdo` equals sample bit 15−i. `dac_sdo` changes only on falling clock edges, never during a high phase and never on a rising edge.
- R7: After the 16th falling edge, `dac_sclk` stays 0 for `HALF_DIV` cycles while `dac_cs_n` is still 0, and only then does `dac_cs_n` rise.
- R8: After `dac_cs_n` rises it stays 1 for `GAP_CYC` cycles, and then `in_ready` returns to 1.
- R9: Whenever `dac_cs_n` is 1, `dac_sclk` and `dac_sdo` are 0.
- R10: While `in_ready` is 0, the value on `in_data` has no effect. The bits sent are the ones present on the accepting edge, and a sample held valid is accepted in the first cycle `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_data | input | DATA_W | Sample to send, two's complement, bit 15 sent first |
| in_ready | output | 1 | Block can accept a sample this cycle |
| dac_cs_n | output | 1 | Active-low converter select |
| dac_sclk | output | 1 | Bit clock, rests low |
| dac_sdo | output | 1 | Serial data to the converter |

## Verification
The bench holds a sample valid throughout the power-up hold-off. A design that ignored the hold-off would start a frame early, and a design that lost the sample would never send it. It sends samples held back to back while scrambling `in_data` whenever `in_ready` is low, so a design that loads data outside the handshake would send corrupted bits. It uses all-zero, all-one and alternating patterns, and samples with only bit 15 set or only bit 15 clear, which expose a design that shifts the wrong way or sends 15 or 17 bits. Lead, tail and gap are given distinct lengths, so a design that mixes up one interval with another, or drops the select before the final falling edge, fails in the exact cycle where it goes wrong.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_GAP
    } link_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dac_spi_interval.sv
module dac_spi_interval #(
    parameter int CNT_W   = 13,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= CNT_W'(RST_VAL);
        else if (load)
            remain_q <= load_val;
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/dac_spi_shreg.sv
module dac_spi_shreg #(
    parameter int DATA_W = 16,
    parameter int BCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              ser_bit,
    output logic [BCNT_W-1:0] bits_left
);

    logic [DATA_W-1:0] word_q;
    logic [BCNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= load_data;
            left_q <= BCNT_W'(DATA_W);
        end else if (shift) begin
            word_q <= {word_q[DATA_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign ser_bit   = word_q[DATA_W-1];
    assign bits_left = left_q;

endmodule

// File: rtl/dac_spi_host.sv
module dac_spi_host
    import dac_spi_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HALF_DIV  = 1,
    parameter int LEAD_CYC  = 1,
    parameter int GAP_CYC   = 1,
    parameter int PWRUP_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo
);

    localparam int MAX_CYC = max_of4(PWRUP_CYC, HALF_DIV, LEAD_CYC, GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int BCNT_W  = $clog2(DATA_W + 1);

    link_state_t      state_q, state_nxt;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             take, shift;
    logic [BCNT_W-1:0] bits_left;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_nxt;
    end

    // next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PWRUP:  if (tmr_done) state_nxt = ST_IDLE;
            ST_IDLE:   if (in_valid) state_nxt = ST_LEAD;
            ST_LEAD:   if (tmr_done) state_nxt = ST_SCK_HI;
            ST_SCK_HI: if (tmr_done) state_nxt = ST_SCK_LO;
            ST_SCK_LO: if (tmr_done) state_nxt = (bits_left == '0) ? ST_GAP : ST_SCK_HI;
            ST_GAP:    if (tmr_done) state_nxt = ST_IDLE;
            default:   state_nxt = ST_PWRUP;
        endcase
    end

    // interval length for the state being entered
    always_comb begin
        unique case (state_nxt)
            ST_LEAD:              tmr_val = CNT_W'(LEAD_CYC - 1);
            ST_SCK_HI, ST_SCK_LO: tmr_val = CNT_W'(HALF_DIV - 1);
            ST_GAP:               tmr_val = CNT_W'(GAP_CYC - 1);
            default:              tmr_val = CNT_W'(PWRUP_CYC - 1);
        endcase
    end

    assign tmr_load = (state_nxt != state_q);
    assign take     = (state_q == ST_IDLE) && in_valid;
    assign shift    = (state_q == ST_SCK_HI) && (state_nxt == ST_SCK_LO);
    assign in_ready = (state_q == ST_IDLE);

    dac_spi_interval #(
        .CNT_W  (CNT_W),
        .RST_VAL(PWRUP_CYC - 1)
    ) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_done)
    );

    dac_spi_shreg #(
        .DATA_W(DATA_W),
        .BCNT_W(BCNT_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_data(in_data),
        .shift    (shift),
        .ser_bit  (dac_sdo),
        .bits_left(bits_left)
    );

    // registered port outputs, driven from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_cs_n <= 1'b1;
            dac_sclk <= 1'b0;
        end else begin
            dac_cs_n <= !((state_nxt == ST_LEAD) || (state_nxt == ST_SCK_HI) ||
                          (state_nxt == ST_SCK_LO));
            dac_sclk <= (state_nxt == ST_SCK_HI);
        end
    end

    // observation of the port: rising edges seen while selected
    logic              chk_sclk_q;
    logic [BCNT_W:0]   chk_rises;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_sclk_q <= 1'b0;
            chk_rises  <= '0;
        end else begin
            chk_sclk_q <= dac_sclk;
            if (dac_cs_n)
                chk_rises <= '0;
            else if (dac_sclk && !chk_sclk_q)
                chk_rises <= chk_rises + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> (!dac_sclk && !dac_sdo)); // R9

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!dac_cs_n && !in_ready)); // R3

    AST_NO_READY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> !in_ready); // R3

    AST_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_sdo)); // R6

    AST_HOLD_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo)); // R6

    AST_CS_FALL_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (!dac_sclk && !$past(dac_sclk))); // R4

    AST_CS_RISE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> !$past(dac_sclk)); // R7

    AST_SIXTEEN_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (chk_rises == (BCNT_W+1)'(DATA_W))); // R5

endmodule

// File: tb/dac_spi_host_tb.sv
module dac_spi_host_tb;

    localparam int DW   = 16;
    localparam int HALF = 2;
    localparam int LEAD = 3;
    localparam int GAP  = 4;
    localparam int PWR  = 200;

    typedef struct {
        logic  cs;
        logic  sclk;
        logic  sdo;
        logic  rdy;
        string ttag;
        string dtag;
        string rtag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, dac_cs_n, dac_sclk, dac_sdo;

    int n_cmp = 0;
    int n_bad = 0;
    int edges = 0;
    int cyc = 0;
    bit waited = 0;
    bit finished = 0;

    exp_t          exp_q[$];
    logic [DW-1:0] stim_q[$];

    always #10 clk = ~clk;

    dac_spi_host #(
        .DATA_W(DW), .HALF_DIV(HALF), .LEAD_CYC(LEAD),
        .GAP_CYC(GAP), .PWRUP_CYC(PWR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
    );

    task automatic chk(input logic act, input logic expv, input string tag, input string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, expv);
        end
    endtask

    // expected per-cycle port values of one frame, starting the cycle after acceptance
    task automatic push_frame(input logic [DW-1:0] d, input bit held);
        string dt;
        dt = held ? "R10" : "R6";
        for (int t = 0; t < LEAD + 32*HALF + GAP; t++) begin
            exp_t e;
            e.rdy = 1'b0;
            e.rtag = "R3";
            e.dtag = dt;
            if (t < LEAD) begin
                e.cs = 0; e.sclk = 0; e.sdo = d[15]; e.ttag = "R4";
            end else if (t < LEAD + 32*HALF) begin
                int u, b;
                bit hi;
                u = t - LEAD;
                b = u / (2*HALF);
                hi = (u % (2*HALF)) < HALF;
                e.cs = 0;
                e.sclk = hi;
                e.sdo = hi ? d[15-b] : ((b == 15) ? 1'b0 : d[14-b]);
                e.ttag = (b == 15 && !hi) ? "R7" : "R5";
            end else begin
                e.cs = 1; e.sclk = 0; e.sdo = 0; e.ttag = "R8"; e.dtag = "R9";
            end
            exp_q.push_back(e);
        end
    endtask

    // compare every cycle, then drive the handshake for the next edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e;
            bit pwr_ok;
            edges++;
            cyc++;
            pwr_ok = (edges >= PWR);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e.cs = 1; e.sclk = 0; e.sdo = 0; e.rdy = pwr_ok;
                e.ttag = pwr_ok ? "R9" : "R2";
                e.dtag = "R9";
                e.rtag = pwr_ok ? "R8" : "R2";
            end
            chk(dac_cs_n, e.cs,   e.ttag, "cs_n");
            chk(dac_sclk, e.sclk, e.ttag, "sclk");
            chk(dac_sdo,  e.sdo,  e.dtag, "sdo");
            chk(in_ready, e.rdy,  e.rtag, "ready");
            if (stim_q.size() > 0) begin
                in_valid = 1'b1;
                // R10: data is scrambled on alternate cycles while not ready
                in_data = (in_ready || !cyc[0]) ? stim_q[0] : ~stim_q[0];
                if (in_ready) begin
                    push_frame(stim_q[0], waited);
                    void'(stim_q.pop_front());
                    waited = 0;
                end else begin
                    waited = 1;
                end
            end else begin
                in_valid = 1'b0;
                in_data = '0;
                waited = 0;
            end
        end
    end

    task automatic drain();
        while (stim_q.size() > 0 || exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(dac_cs_n, 1'b1, "R1", "cs_n");
        chk(dac_sclk, 1'b0, "R1", "sclk");
        chk(dac_sdo,  1'b0, "R1", "sdo");
        chk(in_ready, 1'b0, "R1", "ready");
        // R2: a sample offered during the hold-off waits for it
        stim_q.push_back(16'hA5C3);
        @(negedge clk);
        #2 rst_n = 1'b1;
        drain();
        repeat (10) @(negedge clk);
        // R5 R6 R10: back to back with single-bit extremes
        stim_q.push_back(16'h8000);
        stim_q.push_back(16'h7FFF);
        stim_q.push_back(16'hFFFF);
        drain();
        repeat (7) @(negedge clk);
        stim_q.push_back(16'h0000);
        drain();
        repeat (3) @(negedge clk);
        stim_q.push_back(16'h5A96);
        stim_q.push_back(16'h0001);
        drain();
        repeat (5) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule